// File: doc/BRIEF.md
# Two-Level Interrupt Enable Controller

This block holds one 8-bit interrupt control byte and merges its flags, its enables and a vector of peripheral flags into two registered interrupt requests for a processor: a high-priority request and a low-priority request. It latches three core events: a timer overflow, an external-pin event and a port-change event. Each event sets its flag whether or not it is enabled, so software can also poll the flags. A flag stays set until software writes a zero to it.

A priority-mode input selects what the top two bits of the byte mean. With the mode off, bit 7 gates every interrupt and bit 6 gates only the peripheral group. Every request then goes out on the high-priority line. With the mode on, bit 7 enables high-priority requests and also blocks everything when it is clear, and bit 6 enables low-priority peripheral requests. The core sources are always high priority. Each peripheral source carries its own priority bit. The peripheral flags arrive already latched and masked by their owners. The block only combines them.

Top module: `intr_gate_ctrl`

## Requirements
- R1: After reset both request outputs are 0 and the byte reads 0x00 in bits 7..1. Bit 0 reads the value of the parameter PCHG_RST_VAL.
- R2: A cycle with `wr_en` high loads `wr_data[7:3]` into the enables: bit 7 global/high, bit 6 peripheral/low, bit 5 timer, bit 4 external, bit 3 port-change. The new value is visible on `ctl_q` after the clock edge.
- R3: A pulse on `evt_i[2]` (timer), `evt_i[1]` (external) or `evt_i[0]` (port change) sets byte bit 2, 1 or 0 respectively on the next edge, whatever the state of any enable.
- R4: A flag holds its value until a write carries a 0 in its bit position. A write with 1 in a flag position sets that flag.
- R5: When an event and a write of 0 reach the same flag in one cycle, the flag ends up set.
- R6: With `prio_mode` = 0, `irq_hi` equals bit7 AND (any enabled core flag OR (bit6 AND any peripheral flag)), evaluated on the previous cycle's state and inputs. `irq_lo` stays 0.
- R7: With `prio_mode` = 1, `irq_hi` equals bit7 AND (any enabled core flag OR any peripheral flag whose `periph_prio` bit is 1). `irq_lo` equals bit7 AND bit6 AND any peripheral flag whose priority bit is 0. Both are registered one cycle.
- R8: While bit 7 is 0, both request outputs are 0 on the following cycle in either mode, even when every flag and every other enable is set.
- R9: With `prio_mode` = 0 and bit 6 clear, peripheral flags raise no request, but enabled core flags still do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_mode | input | 1 | 1 selects two-level priority mode |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Value written to the control byte |
| evt_i | input | 3 | Event pulses: [2] timer, [1] external, [0] port change |
| periph_flag | input | NUM_PERIPH | Latched peripheral interrupt flags |
| periph_prio | input | NUM_PERIPH | Per-peripheral priority, 1 = high |
| ctl_q | output | 8 | Control byte read value |
| irq_hi | output | 1 | Registered high-priority request |
| irq_lo | output | 1 | Registered low-priority request |

## Verification
The random stream mixes writes, sparse event pulses, peripheral flags and priority bits, and toggles the mode. This separates the two meanings of bits 7 and 6. It also shows whether a peripheral request is routed to the correct output line. Directed steps collide an event with a clearing write to tell a set-wins flag from a clear-wins flag. They hold bit 7 low with every source active to expose any path that bypasses the global gate. With the mode off and bit 6 clear, peripheral flags alone are applied to separate the peripheral gate from the global gate.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;
   localparam int unsigned CTL_W  = 8;
   localparam int unsigned CORE_N = 3;

   typedef struct packed {
      logic gate_a;     // global, or high-priority gate
      logic gate_b;     // peripheral, or low-priority gate
      logic tmr_en;
      logic ext_en;
      logic pchg_en;
      logic tmr_flag;
      logic ext_flag;
      logic pchg_flag;
   } ictl_t;
endpackage

// File: rtl/intr_flag_cell.sv
module intr_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic wr_val_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= RST_VAL;
      else if (set_i)  flag_q <= 1'b1;
      else if (wr_i)   flag_q <= wr_val_i;
   end

   assign flag_o = flag_q;

   // R3 R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);

   // R4
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !wr_i) |=> $stable(flag_o));
endmodule

// File: rtl/intr_ctrl_reg.sv
module intr_ctrl_reg
   import intr_gate_pkg::*;
#(
   parameter logic PCHG_RST_VAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTL_W-1:0]  wr_data,
   input  logic [CORE_N-1:0] evt_i,
   output ictl_t             ctl
);
   localparam int unsigned EN_W = CTL_W - CORE_N;

   logic [EN_W-1:0]   en_q;
   logic [CORE_N-1:0] flag_w;

   initial begin
      if (CTL_W != 8) $error("control byte must be 8 bits");
      if (EN_W != 5)  $error("enable field must be 5 bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (wr_en)  en_q <= wr_data[CTL_W-1:CORE_N];
   end

   for (genvar gi = 0; gi < CORE_N; gi++) begin : g_flag
      localparam logic RV = (gi == 0) ? PCHG_RST_VAL : 1'b0;
      intr_flag_cell #(.RST_VAL(RV)) flag_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (evt_i[gi]),
         .wr_i     (wr_en),
         .wr_val_i (wr_data[gi]),
         .flag_o   (flag_w[gi])
      );
   end

   assign ctl = ictl_t'({en_q, flag_w});

   // R2
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl.gate_a == $past(wr_data[7]) && ctl.tmr_en == $past(wr_data[5])));
endmodule

// File: rtl/intr_req_merge.sv
module intr_req_merge
   import intr_gate_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  prio_mode,
   input  ictl_t                 ctl,
   input  logic [NUM_PERIPH-1:0] periph_flag,
   input  logic [NUM_PERIPH-1:0] periph_prio,
   output logic                  irq_hi,
   output logic                  irq_lo
);
   logic [NUM_PERIPH-1:0] p_hi, p_lo;
   logic core_any, hi_d, lo_d, hi_q, lo_q;

   initial begin
      if (NUM_PERIPH < 1 || NUM_PERIPH > 32) $error("NUM_PERIPH out of range");
   end

   for (genvar gi = 0; gi < NUM_PERIPH; gi++) begin : g_split
      assign p_hi[gi] = periph_flag[gi] &  periph_prio[gi];
      assign p_lo[gi] = periph_flag[gi] & ~periph_prio[gi];
   end

   assign core_any = (ctl.tmr_en  & ctl.tmr_flag)
                   | (ctl.ext_en  & ctl.ext_flag)
                   | (ctl.pchg_en & ctl.pchg_flag);

   always_comb begin
      if (prio_mode) begin
         hi_d = ctl.gate_a & (core_any | (|p_hi));
         lo_d = ctl.gate_a & ctl.gate_b & (|p_lo);
      end else begin
         hi_d = ctl.gate_a & (core_any | (ctl.gate_b & (|periph_flag)));
         lo_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_d;
         lo_q <= lo_d;
      end
   end

   assign irq_hi = hi_q;
   assign irq_lo = lo_q;

   // R8
   gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.gate_a |=> (!irq_hi && !irq_lo));

   // R6
   flat_no_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prio_mode |=> !irq_lo);

   // R9
   periph_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!prio_mode && !ctl.gate_b && !core_any) |=> !irq_hi);
endmodule

// File: rtl/intr_gate_ctrl.sv
module intr_gate_ctrl
   import intr_gate_pkg::*;
#(
   parameter int unsigned NUM_PERIPH   = 4,
   parameter logic        PCHG_RST_VAL = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  prio_mode,
   input  logic                  wr_en,
   input  logic [7:0]            wr_data,
   input  logic [2:0]            evt_i,
   input  logic [NUM_PERIPH-1:0] periph_flag,
   input  logic [NUM_PERIPH-1:0] periph_prio,
   output logic [7:0]            ctl_q,
   output logic                  irq_hi,
   output logic                  irq_lo
);
   ictl_t ctl;

   intr_ctrl_reg #(.PCHG_RST_VAL(PCHG_RST_VAL)) reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .evt_i   (evt_i),
      .ctl     (ctl)
   );

   intr_req_merge #(.NUM_PERIPH(NUM_PERIPH)) merge_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .prio_mode   (prio_mode),
      .ctl         (ctl),
      .periph_flag (periph_flag),
      .periph_prio (periph_prio),
      .irq_hi      (irq_hi),
      .irq_lo      (irq_lo)
   );

   assign ctl_q = ctl;

   // R1
   rst_req_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!irq_hi && !irq_lo));
endmodule

// File: tb/intr_gate_ctrl_tb_top.sv
module intr_gate_ctrl_tb_top;
   localparam int unsigned NP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prio_mode = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] evt_i = '0;
   logic [NP-1:0] periph_flag = '0;
   logic [NP-1:0] periph_prio = '0;
   logic [7:0] ctl_q;
   logic irq_hi, irq_lo;

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] m_reg;

   always #10 clk = ~clk;

   intr_gate_ctrl #(.NUM_PERIPH(NP), .PCHG_RST_VAL(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode), .wr_en(wr_en),
      .wr_data(wr_data), .evt_i(evt_i), .periph_flag(periph_flag),
      .periph_prio(periph_prio), .ctl_q(ctl_q), .irq_hi(irq_hi), .irq_lo(irq_lo)
   );

   function automatic logic [1:0] exp_irq(input logic [7:0] r, input logic md,
                                          input logic [NP-1:0] pf, input logic [NP-1:0] pp);
      logic core;
      core = |(r[5:3] & r[2:0]);
      if (md) return {r[7] & (core | (|(pf & pp))), r[7] & r[6] & (|(pf & ~pp))};
      else    return {r[7] & (core | (r[6] & (|pf))), 1'b0};
   endfunction

   function automatic logic [7:0] next_reg(input logic [7:0] r, input logic w,
                                           input logic [7:0] d, input logic [2:0] e);
      logic [7:0] n;
      n = w ? d : r;
      n[2:0] = n[2:0] | e;
      return n;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
      n_vec++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, expv);
      end
   endtask

   // called at a negedge; drives one cycle and checks at the next negedge
   task automatic step(input string tag, input logic md, input logic w, input logic [7:0] d,
                       input logic [2:0] e, input logic [NP-1:0] pf, input logic [NP-1:0] pp);
      logic [1:0] ei;
      prio_mode = md; wr_en = w; wr_data = d; evt_i = e;
      periph_flag = pf; periph_prio = pp;
      ei = exp_irq(m_reg, md, pf, pp);
      m_reg = next_reg(m_reg, w, d, e);
      @(posedge clk);
      @(negedge clk);
      check({tag, " reg R2 R3 R4"}, ctl_q, m_reg);
      check({tag, " irq"}, {6'd0, irq_hi, irq_lo}, {6'd0, ei});
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, port-change flag reset forced to 1 by parameter
      check("R1 reset byte", ctl_q, 8'h01);
      check("R1 reset irq", {6'd0, irq_hi, irq_lo}, 8'h00);
      m_reg = 8'h01;

      // R4: clear everything, then R3: events with all enables off
      step("R4 clear", 1'b0, 1'b1, 8'h00, 3'b000, '0, '0);
      step("R3 evt", 1'b0, 1'b0, 8'h00, 3'b101, '0, '0);
      step("R4 hold", 1'b0, 1'b0, 8'h00, 3'b000, '0, '0);
      // R5: set and clear collide
      step("R5 collide", 1'b0, 1'b1, 8'h00, 3'b111, '0, '0);
      // R8: gate off with every source active, both modes
      step("R8 gate off", 1'b0, 1'b1, 8'h7F, 3'b111, '1, 4'b0101);
      step("R8 gate off", 1'b0, 1'b0, 8'h00, 3'b000, '1, 4'b0101);
      step("R8 gate off pm", 1'b1, 1'b0, 8'h00, 3'b000, '1, 4'b0101);
      step("R8 gate off pm", 1'b1, 1'b0, 8'h00, 3'b000, '1, 4'b0101);
      // R9: flat mode, bit6 clear, peripherals only
      step("R9 setup", 1'b0, 1'b1, 8'h80, 3'b000, '1, '0);
      step("R9 periph blocked", 1'b0, 1'b0, 8'h00, 3'b000, '1, '0);
      step("R9 periph blocked", 1'b0, 1'b0, 8'h00, 3'b000, '1, '0);
      step("R9 core passes", 1'b0, 1'b1, 8'hA4, 3'b000, '0, '0);
      step("R9 core passes", 1'b0, 1'b0, 8'h00, 3'b000, '0, '0);
      // R7: low-priority only peripheral in priority mode
      step("R7 lo setup", 1'b1, 1'b1, 8'hC0, 3'b000, 4'b0010, 4'b0000);
      step("R7 lo", 1'b1, 1'b0, 8'h00, 3'b000, 4'b0010, 4'b0000);
      step("R7 hi", 1'b1, 1'b0, 8'h00, 3'b000, 4'b0010, 4'b0010);

      // R6 R7 random stream
      for (int i = 0; i < 3000; i++) begin
         logic md, w;
         logic [2:0] e;
         md = 1'($urandom_range(0, 1));
         w  = ($urandom_range(0, 3) == 0);
         e  = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
               ($urandom_range(0, 7) == 0)};
         step(md ? "R7 rand" : "R6 rand", md, w, 8'($urandom),
              e, NP'($urandom) & NP'($urandom), NP'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule